// File: doc/BRIEF.md
# GPIO Unit with Pin Interrupts

This block is a register-mapped general-purpose I/O unit with 32 pins on a simple synchronous 16-bit register port addressed by halfword. Each pin has a 2-bit mode field that decides whether the unit drives it. Each pin also has a data bit. A read of a data register returns the output latch for driven pins and the synchronised pin level for all other pins.

The lower 16 pins can raise interrupts. Each of them has a 2-bit trigger field that selects low level, high level, rising edge or falling edge. A detected event sets a latched status bit. Software clears that bit by writing 1 to it. A status bit reaches the single interrupt output only when its mask bit is 0 and its enable bit is 1. The interrupt output is a registered OR over all such bits and goes to a parent interrupt controller.

Top module: `gpio_irq_unit`

## Requirements
- R1: While rst_ni is low, every register reads 0, no pin is driven (pin_oe_o = 0) and irq_o is 0.
- R2: Halfword 0 maps pins 0–15 and halfword 1 maps pins 16–31, one bit per pin. A write loads the output latch. A read returns, for each pin, the latch when the pin is driven and otherwise the pin level as sampled two clock edges earlier.
- R3: Pin n has a mode field at halfword 2 + n/8, bits 2·(n mod 8)+1 down to 2·(n mod 8). Code 01 drives the pin (pin_oe_o[n] = 1, pin_o[n] = latch). Codes 00, 10 and 11 leave it undriven.
- R4: Pin n < 16 has a trigger field at bits 2·(n mod 8)+1 down to 2·(n mod 8). Pins 0–7 are in halfword 7 and pins 8–15 are in halfword 6. The codes are 00 = low level, 01 = high level, 10 = rising edge, 11 = falling edge.
- R5: Under a level trigger the status bit is set on every cycle the level is active. A clear therefore only takes effect once the pin has left that level.
- R6: Under an edge trigger the status bit is set once by the matching transition. It then stays set until it is cleared, whatever the pin does afterwards.
- R7: Halfword 8 is status. Writing 1 to bit n clears pin n's status. Writing 0 leaves the bit unchanged.
- R8: An event detected in the same cycle as a clear of its bit leaves the bit set.
- R9: Halfword 9 is the mask (1 = masked) and halfword 10 is the enable (1 = enabled). irq_o is the registered OR over n of status[n] & ~mask[n] & enable[n].
- R10: A pin change is visible in status at the third rising clock edge after it and on irq_o one edge later.
- R11: Halfwords 11–15 read as 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 4 | Halfword address |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for addr_i (combinational) |
| pin_i | input | 32 | Pin levels from the pads |
| pin_o | output | 32 | Output latch to the pads |
| pin_oe_o | output | 32 | Pad drive enable |
| irq_o | output | 1 | Interrupt to the parent controller |

## Verification
The bench builds the block with its default parameters: 32 pins, 16 interrupt-capable pins and 16-bit halfwords. With these values the register map has two data halfwords, four mode halfwords and two trigger halfwords. The trigger halfwords are stored in reversed order, so the bench can probe that pins 0–7 sit at the higher address. The defaults also give full 16-bit status, mask and enable words. Under these values all four trigger codes, the clear-versus-event collision and the three-edge detection latency can be checked at the ports.

// File: rtl/gpio_unit_pkg.sv
package gpio_unit_pkg;

  typedef enum logic [1:0] {
    TRIG_LOW  = 2'b00,
    TRIG_HIGH = 2'b01,
    TRIG_RISE = 2'b10,
    TRIG_FALL = 2'b11
  } trig_e;

  localparam logic [1:0] MODE_IN  = 2'b00;
  localparam logic [1:0] MODE_OUT = 2'b01;

  localparam int unsigned PINS_PER_FIELD_REG = 8;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] meta_q, stab_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= d_i;
      stab_q <= meta_q;
    end
  end

  assign q_o = stab_q;

endmodule

// File: rtl/gpio_event_detect.sv
module gpio_event_detect
  import gpio_unit_pkg::*;
#(
  parameter int unsigned N = 16
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [N-1:0]   smp_i,
  input  logic [2*N-1:0] trig_i,
  input  logic [N-1:0]   clr_i,
  output logic [N-1:0]   status_o
);

  logic [N-1:0] prev_q, hit, status_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= smp_i;
  end

  always_comb begin
    for (int n = 0; n < N; n++) begin
      unique case (trig_e'(trig_i[2*n +: 2]))
        TRIG_LOW:  hit[n] = ~smp_i[n];
        TRIG_HIGH: hit[n] =  smp_i[n];
        TRIG_RISE: hit[n] =  smp_i[n] & ~prev_q[n];
        default:   hit[n] = ~smp_i[n] &  prev_q[n];
      endcase
    end
  end

  // event wins over a simultaneous clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_q <= '0;
    else         status_q <= (status_q & ~clr_i) | hit;
  end

  assign status_o = status_q;

  for (genvar n = 0; n < N; n++) begin : g_chk
    assert_w1c_only_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(status_q[n]) |-> $past(clr_i[n]));
    assert_event_kept_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hit[n] |=> status_q[n]);
    assert_edge_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (trig_i[2*n+1] && status_q[n] && !clr_i[n]) |=> status_q[n]);
  end

endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
  import gpio_unit_pkg::*;
#(
  parameter int unsigned NUM_PINS = 32,
  parameter int unsigned NUM_IRQ  = 16,
  parameter int unsigned DW       = 16,
  parameter int unsigned AW       = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [AW-1:0]        addr_i,
  input  logic                 we_i,
  input  logic [DW-1:0]        wdata_i,
  output logic [DW-1:0]        rdata_o,
  input  logic [NUM_PINS-1:0]  smp_i,
  input  logic [NUM_IRQ-1:0]   status_i,
  output logic [NUM_PINS-1:0]  out_o,
  output logic [NUM_PINS-1:0]  oe_o,
  output logic [2*NUM_IRQ-1:0] trig_o,
  output logic [NUM_IRQ-1:0]   mask_o,
  output logic [NUM_IRQ-1:0]   en_o,
  output logic [NUM_IRQ-1:0]   clr_o
);

  localparam int unsigned DATA_REGS = NUM_PINS / DW;
  localparam int unsigned MODE_REGS = 2 * NUM_PINS / DW;
  localparam int unsigned TRIG_REGS = 2 * NUM_IRQ / DW;
  localparam int unsigned DATA_BASE = 0;
  localparam int unsigned MODE_BASE = DATA_BASE + DATA_REGS;
  localparam int unsigned TRIG_BASE = MODE_BASE + MODE_REGS;
  localparam int unsigned STAT_ADDR = TRIG_BASE + TRIG_REGS;
  localparam int unsigned MASK_ADDR = STAT_ADDR + 1;
  localparam int unsigned EN_ADDR   = STAT_ADDR + 2;

  logic [NUM_PINS-1:0]   data_q;
  logic [2*NUM_PINS-1:0] mode_q;
  logic [2*NUM_IRQ-1:0]  trig_q;  // stored in pin order
  logic [NUM_IRQ-1:0]    mask_q, en_q;
  logic [NUM_PINS-1:0]   pin_view;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      mode_q <= '0;
      trig_q <= '0;
      mask_q <= '0;
      en_q   <= '0;
    end else if (we_i) begin
      for (int i = 0; i < DATA_REGS; i++)
        if (addr_i == AW'(DATA_BASE + i)) data_q[i*DW +: DW] <= wdata_i;
      for (int i = 0; i < MODE_REGS; i++)
        if (addr_i == AW'(MODE_BASE + i)) mode_q[i*DW +: DW] <= wdata_i;
      // lowest pin group sits in the highest trigger halfword
      for (int g = 0; g < TRIG_REGS; g++)
        if (addr_i == AW'(TRIG_BASE + TRIG_REGS - 1 - g)) trig_q[g*DW +: DW] <= wdata_i;
      if (addr_i == AW'(MASK_ADDR)) mask_q <= wdata_i[NUM_IRQ-1:0];
      if (addr_i == AW'(EN_ADDR))   en_q   <= wdata_i[NUM_IRQ-1:0];
    end
  end

  for (genvar n = 0; n < NUM_PINS; n++) begin : g_pin
    assign oe_o[n]     = (mode_q[2*n +: 2] == MODE_OUT);
    assign pin_view[n] = oe_o[n] ? data_q[n] : smp_i[n];
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < DATA_REGS; i++)
      if (addr_i == AW'(DATA_BASE + i)) rdata_o = pin_view[i*DW +: DW];
    for (int i = 0; i < MODE_REGS; i++)
      if (addr_i == AW'(MODE_BASE + i)) rdata_o = mode_q[i*DW +: DW];
    for (int g = 0; g < TRIG_REGS; g++)
      if (addr_i == AW'(TRIG_BASE + TRIG_REGS - 1 - g)) rdata_o = trig_q[g*DW +: DW];
    if (addr_i == AW'(STAT_ADDR)) rdata_o = DW'(status_i);
    if (addr_i == AW'(MASK_ADDR)) rdata_o = DW'(mask_q);
    if (addr_i == AW'(EN_ADDR))   rdata_o = DW'(en_q);
  end

  assign clr_o  = (we_i && addr_i == AW'(STAT_ADDR)) ? wdata_i[NUM_IRQ-1:0] : '0;
  assign out_o  = data_q;
  assign trig_o = trig_q;
  assign mask_o = mask_q;
  assign en_o   = en_q;

  assert_drive_mode_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == AW'(MODE_BASE) && wdata_i[1:0] == MODE_IN) |=> !oe_o[0]);

endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit #(
  parameter int unsigned NUM_PINS = 32,
  parameter int unsigned NUM_IRQ  = 16,
  parameter int unsigned DW       = 16,
  parameter int unsigned AW       = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [AW-1:0]       addr_i,
  input  logic                we_i,
  input  logic [DW-1:0]       wdata_i,
  output logic [DW-1:0]       rdata_o,
  input  logic [NUM_PINS-1:0] pin_i,
  output logic [NUM_PINS-1:0] pin_o,
  output logic [NUM_PINS-1:0] pin_oe_o,
  output logic                irq_o
);

  logic [NUM_PINS-1:0]  smp;
  logic [2*NUM_IRQ-1:0] trig;
  logic [NUM_IRQ-1:0]   status, mask, en, clr;
  logic                 irq_q;

  gpio_sync #(.W(NUM_PINS)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (smp)
  );

  gpio_event_detect #(.N(NUM_IRQ)) u_det (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .smp_i   (smp[NUM_IRQ-1:0]),
    .trig_i  (trig),
    .clr_i   (clr),
    .status_o(status)
  );

  gpio_regfile #(
    .NUM_PINS(NUM_PINS),
    .NUM_IRQ (NUM_IRQ),
    .DW      (DW),
    .AW      (AW)
  ) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .addr_i  (addr_i),
    .we_i    (we_i),
    .wdata_i (wdata_i),
    .rdata_o (rdata_o),
    .smp_i   (smp),
    .status_i(status),
    .out_o   (pin_o),
    .oe_o    (pin_oe_o),
    .trig_o  (trig),
    .mask_o  (mask),
    .en_o    (en),
    .clr_o   (clr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |(status & ~mask & en);
  end

  assign irq_o = irq_q;

  assert_irq_gated_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((~mask & en) == '0) |=> !irq_o);
  assert_irq_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status == '0) |=> !irq_o);
  assert_reset_quiet_R1: assert property (@(posedge clk_i)
    !rst_ni |-> (!irq_o && pin_oe_o == '0));

endmodule

// File: tb/sim_gpio_irq_unit.sv
module sim_gpio_irq_unit;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  addr = '0;
  logic        we = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [31:0] pin_i = '0;
  logic [31:0] pin_o, pin_oe;
  logic        irq;
  int          n_vec = 0;
  int          n_bad = 0;

  always #2.5 clk = ~clk;

  gpio_irq_unit u0 (
    .clk_i   (clk),
    .rst_ni  (rst_ni),
    .addr_i  (addr),
    .we_i    (we),
    .wdata_i (wdata),
    .rdata_o (rdata),
    .pin_i   (pin_i),
    .pin_o   (pin_o),
    .pin_oe_o(pin_oe),
    .irq_o   (irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // all tasks start and end just after a falling edge
  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    addr = a;
    #0.5;
    d = rdata;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [15:0] d;
    for (int a = 0; a < 11; a++) begin
      rd(4'(a), d);
      check($sformatf("R1 reg %0d", a), 32'(d), 32'h0);
    end
    check("R1 oe", pin_oe, 32'h0);
    check("R1 irq", 32'(irq), 32'h0);
  endtask

  task automatic t_setup();
    logic [15:0] d;
    wr(4'd6, 16'hAAAA);
    wr(4'd7, 16'hAAAA);
    wr(4'd8, 16'hFFFF);
    rd(4'd8, d);
    check("R7 initial clear", 32'(d), 32'h0);
  endtask

  task automatic t_data_mode();
    logic [15:0] d;
    wr(4'd2, 16'h0049);  // pin0=01 pin1=10 pin3=01
    wr(4'd0, 16'h000B);
    check("R3 oe low", 32'(pin_oe[15:0]), 32'h0009);
    check("R3 driven data", 32'(pin_o[15:0] & pin_oe[15:0]), 32'h0009);
    rd(4'd0, d);
    check("R2 read low", 32'(d), 32'h0009);
    pin_i[1] = 1'b1;
    wait_cyc(2);
    rd(4'd0, d);
    check("R2 read mixed", 32'(d), 32'h000B);
    wr(4'd4, 16'h0004);  // pin17=01
    wr(4'd1, 16'h0002);
    pin_i[31] = 1'b1;
    check("R3 oe high", 32'(pin_oe[31:16]), 32'h0002);
    wait_cyc(2);
    rd(4'd1, d);
    check("R2 read high", 32'(d), 32'h8002);
    pin_i[1] = 1'b0;
    wait_cyc(3);
    wr(4'd8, 16'hFFFF);
  endtask

  task automatic t_latency();
    logic [15:0] d;
    wr(4'd10, 16'h0004);
    pin_i[2] = 1'b1;
    wait_cyc(2);
    rd(4'd8, d);
    check("R10 not yet", 32'(d), 32'h0);
    wait_cyc(1);
    rd(4'd8, d);
    check("R10 status edge3", 32'(d), 32'h0004);
    check("R10 irq lag", 32'(irq), 32'h0);
    wait_cyc(1);
    check("R10 irq edge4", 32'(irq), 32'h1);
    pin_i[2] = 1'b0;
    wait_cyc(4);
    rd(4'd8, d);
    check("R6 rise sticky", 32'(d), 32'h0004);
  endtask

  task automatic t_falling();
    logic [15:0] d;
    wr(4'd6, 16'hAAAE);  // pin9 falling
    pin_i[9] = 1'b1;
    wait_cyc(4);
    rd(4'd8, d);
    check("R4 fall ignores rise", 32'(d), 32'h0004);
    pin_i[9] = 1'b0;
    wait_cyc(4);
    rd(4'd8, d);
    check("R4 fall detected", 32'(d), 32'h0204);
  endtask

  task automatic t_w1c();
    logic [15:0] d;
    wr(4'd8, 16'h0000);
    rd(4'd8, d);
    check("R7 zero no effect", 32'(d), 32'h0204);
    wr(4'd8, 16'h0004);
    rd(4'd8, d);
    check("R7 clear one", 32'(d), 32'h0200);
    wr(4'd8, 16'h0200);
    rd(4'd8, d);
    check("R7 clear other", 32'(d), 32'h0);
    wait_cyc(1);
    check("R9 irq drops", 32'(irq), 32'h0);
  endtask

  task automatic t_gating();
    logic [15:0] d;
    pin_i[2] = 1'b1;
    wait_cyc(4);
    check("R9 unmasked enabled", 32'(irq), 32'h1);
    wr(4'd9, 16'h0004);
    wait_cyc(1);
    check("R9 masked", 32'(irq), 32'h0);
    wr(4'd9, 16'h0000);
    wr(4'd10, 16'h0000);
    wait_cyc(1);
    check("R9 disabled", 32'(irq), 32'h0);
    wr(4'd10, 16'h0008);
    wait_cyc(1);
    check("R9 other pin enabled", 32'(irq), 32'h0);
    wr(4'd10, 16'h0004);
    wait_cyc(1);
    check("R9 reenabled", 32'(irq), 32'h1);
    rd(4'd8, d);
    check("R9 status kept", 32'(d), 32'h0004);
    wr(4'd8, 16'h0004);
    wr(4'd10, 16'h0000);
    pin_i[2] = 1'b0;
  endtask

  task automatic t_race();
    logic [15:0] d;
    pin_i[4] = 1'b1;
    wait_cyc(2);
    wr(4'd8, 16'h0010);  // clear lands on the detection edge
    rd(4'd8, d);
    check("R8 event survives clear", 32'(d), 32'h0010);
    wr(4'd8, 16'h0010);
    rd(4'd8, d);
    check("R8 later clear", 32'(d), 32'h0);
  endtask

  task automatic t_level();
    logic [15:0] d;
    wr(4'd7, 16'h86AA);  // pin5 high level, pin6 low level
    pin_i[5] = 1'b1;
    wait_cyc(4);
    rd(4'd8, d);
    check("R5 levels set", 32'(d), 32'h0060);
    wr(4'd8, 16'h0060);
    rd(4'd8, d);
    check("R5 clear while active", 32'(d), 32'h0060);
    pin_i[5] = 1'b0;
    pin_i[6] = 1'b1;
    wait_cyc(4);
    wr(4'd8, 16'h0060);
    rd(4'd8, d);
    check("R5 clear after release", 32'(d), 32'h0);
    rd(4'd7, d);
    check("R4 trig readback", 32'(d), 32'h86AA);
    wr(4'd7, 16'hAAAA);
  endtask

  task automatic t_unmapped();
    logic [15:0] d;
    wr(4'd12, 16'hFFFF);
    wr(4'd15, 16'hFFFF);
    rd(4'd12, d);
    check("R11 unmapped read", 32'(d), 32'h0);
    rd(4'd9, d);
    check("R11 mask intact", 32'(d), 32'h0);
    rd(4'd10, d);
    check("R11 enable intact", 32'(d), 32'h0);
    rd(4'd6, d);
    check("R11 trig intact", 32'(d), 32'hAAAE);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_vec++;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    wait_cyc(2);
    t_reset();
    rst_ni = 1'b1;
    wait_cyc(1);
    t_setup();
    t_data_mode();
    t_latency();
    t_falling();
    t_w1c();
    t_gating();
    t_race();
    t_level();
    t_unmapped();
    wait_cyc(2);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule